// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a processor that fetches fixed 32-bit, word-aligned instructions, and picks the address it fetches next. Each cycle the fetch and decode logic give it four things: the offset and target fields of the current instruction, the kind of branch, and whether the two compared register operands are equal. It also receives a jump-register value and a few control bits. From these it forms one of four next addresses and loads it into the PC on the next rising clock edge. The four addresses are the next sequential word, a PC-relative branch target, a pseudo-direct jump target, and a register-indirect target.

The unit always presents PC+4 as a link address. It also gives a write strobe for the link register when a jump-and-link is accepted. A stall freezes the PC. A synchronous active-low reset loads a fixed boot address. A jump-register value that is not word aligned raises a flag, and the unit still follows it, so that a fault handler can deal with the error.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC is loaded with 0x00400000 (parameter `RESET_PC`). This holds even when `stall` is high.
- R2: With no stall, no jump, no jump-register and no taken branch, the PC advances by 4 at each rising edge. `br_kind` code 2'b00 means no branch, and the reserved code 2'b11 behaves the same way.
- R3: When `stall` is high and reset is not active, the PC keeps its value at the edge.
- R4: When `br_kind` is 2'b01 (branch if equal) and `ops_equal` is 1, the next PC is PC+4 plus the 16-bit offset, sign-extended and shifted left by 2.
- R5: When `br_kind` is 2'b10 (branch if not equal), the branch is taken when `ops_equal` is 0. A branch whose condition fails advances the PC by 4.
- R6: When `jmp` or `jal` is high, the next PC is {PC+4 bits 31:28, `tgt26`, 2'b00}. For example, a field of 2500 gives byte address 10000 when the upper bits are zero.
- R7: When `jreg` is high, the next PC is `jreg_val`. The jump-register input has priority over `jmp`/`jal`, and `jmp`/`jal` have priority over a branch.
- R8: `link_addr` always equals PC+4. `link_we` is high exactly when `jal` is high and `stall` is low.
- R9: `misalign` is high exactly when `jreg` is high and `jreg_val[1:0]` is nonzero. The PC is still loaded with the unaligned value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Hold the PC |
| br_kind | input | 2 | 00 none, 01 branch if equal, 10 branch if not equal, 11 none |
| ops_equal | input | 1 | Register operands compare equal |
| ofs16 | input | 16 | Branch word offset field |
| tgt26 | input | 26 | Jump word-index field |
| jmp | input | 1 | Pseudo-direct jump |
| jal | input | 1 | Pseudo-direct jump with link |
| jreg | input | 1 | Register-indirect jump |
| jreg_val | input | 32 | Register value for the indirect jump |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | PC+4, return address |
| link_we | output | 1 | Write the link register this cycle |
| misalign | output | 1 | Jump-register target not word aligned |

## Verification
The bench uses a negative branch offset. A design that did not sign-extend the offset would send the PC far forward instead of back. It also runs a pseudo-direct jump from a PC whose top nibble is nonzero, which would lose those bits if they were dropped or taken from the wrong source. The bench enables a jump-register, a jump and a taken branch in the same cycle to expose a wrong priority order. It also raises reset together with stall, which a design that checked stall first would ignore. An unaligned jump-register value checks that the flag rises and that the PC still takes the value, rather than blocking the update or rounding it.

// File: rtl/npc_pkg.sv
// Shared types and constants for the next program counter unit.
// Assumes the branch-kind code is produced by the instruction decoder.
package npc_pkg;
    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_EQ   = 2'b01,
        BR_NE   = 2'b10,
        BR_RSV  = 2'b11
    } br_kind_t;

    localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/npc_target_gen.sv
// Forms the sequential, PC-relative and pseudo-direct candidate addresses
// from the current PC and the instruction fields.
// Assumes PC_W = TGT_W + 2 + number of kept upper bits.
module npc_target_gen #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned OFS_W = 16,
    parameter int unsigned TGT_W = 26
) (
    input  logic [PC_W-1:0]  pc_cur,
    input  logic [OFS_W-1:0] ofs,
    input  logic [TGT_W-1:0] tgt,
    output logic [PC_W-1:0]  seq_addr,
    output logic [PC_W-1:0]  br_addr,
    output logic [PC_W-1:0]  jmp_addr
);
    localparam int unsigned HI_W  = PC_W - TGT_W - 2;
    localparam int unsigned EXT_W = PC_W - OFS_W - 2;

    logic [PC_W-1:0] ofs_bytes;

    // Sequential address and sign-extended byte offset.
    always_comb begin
        seq_addr  = pc_cur + PC_W'(npc_pkg::INSN_BYTES);
        ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
        br_addr   = seq_addr + ofs_bytes;
    end

    // Pseudo-direct target keeps the upper bits of the sequential address.
    generate
        if (HI_W > 0) begin : g_keep_hi
            assign jmp_addr = {seq_addr[PC_W-1 -: HI_W], tgt, 2'b00};
        end else begin : g_no_hi
            assign jmp_addr = {tgt, 2'b00};
        end
    endgenerate
endmodule

// File: rtl/npc_select.sv
// Chooses the next PC: jump-register first, then pseudo-direct jump,
// then a taken branch, else sequential. Also flags unaligned
// jump-register values. Purely combinational.
module npc_select #(
    parameter int unsigned PC_W = 32
) (
    input  npc_pkg::br_kind_t br_kind,
    input  logic              ops_equal,
    input  logic              jmp_any,
    input  logic              jreg,
    input  logic [PC_W-1:0]   jreg_val,
    input  logic [PC_W-1:0]   seq_addr,
    input  logic [PC_W-1:0]   br_addr,
    input  logic [PC_W-1:0]   jmp_addr,
    output logic [PC_W-1:0]   next_pc,
    output logic              bad_align
);
    logic br_taken;

    // Branch condition evaluation.
    always_comb begin
        unique case (br_kind)
            npc_pkg::BR_EQ: br_taken = ops_equal;
            npc_pkg::BR_NE: br_taken = !ops_equal;
            default:        br_taken = 1'b0;
        endcase
    end

    // Priority selection of the next address.
    always_comb begin
        if (jreg)          next_pc = jreg_val;
        else if (jmp_any)  next_pc = jmp_addr;
        else if (br_taken) next_pc = br_addr;
        else               next_pc = seq_addr;
    end

    // Alignment check on the register target.
    assign bad_align = jreg && (jreg_val[1:0] != 2'b00);
endmodule

// File: rtl/npc_reg.sv
// PC state register with synchronous active-low reset and hold.
// Reset wins over hold.
module npc_reg #(
    parameter int unsigned PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [PC_W-1:0] next_pc,
    output logic [PC_W-1:0] pc_q
);
    // Load boot address, hold, or take the next address.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= RESET_PC;
        else if (!hold) pc_q <= next_pc;
    end
endmodule

// File: rtl/npc_unit.sv
// Next program counter unit: registered PC with sequential, PC-relative,
// pseudo-direct and register-indirect next-address selection.
// Assumes decode presents fields and controls for the instruction at pc.
module npc_unit #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned OFS_W = 16,
    parameter int unsigned TGT_W = 26,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic [1:0]       br_kind,
    input  logic             ops_equal,
    input  logic [OFS_W-1:0] ofs16,
    input  logic [TGT_W-1:0] tgt26,
    input  logic             jmp,
    input  logic             jal,
    input  logic             jreg,
    input  logic [PC_W-1:0]  jreg_val,
    output logic [PC_W-1:0]  pc,
    output logic [PC_W-1:0]  link_addr,
    output logic             link_we,
    output logic             misalign
);
    logic [PC_W-1:0] seq_addr, br_addr, jmp_addr, next_pc;

    npc_target_gen #(.PC_W(PC_W), .OFS_W(OFS_W), .TGT_W(TGT_W)) u_tgt (
        .pc_cur   (pc),
        .ofs      (ofs16),
        .tgt      (tgt26),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    npc_select #(.PC_W(PC_W)) u_sel (
        .br_kind   (npc_pkg::br_kind_t'(br_kind)),
        .ops_equal (ops_equal),
        .jmp_any   (jmp | jal),
        .jreg      (jreg),
        .jreg_val  (jreg_val),
        .seq_addr  (seq_addr),
        .br_addr   (br_addr),
        .jmp_addr  (jmp_addr),
        .next_pc   (next_pc),
        .bad_align (misalign)
    );

    npc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (stall),
        .next_pc (next_pc),
        .pc_q    (pc)
    );

    // Link outputs for jump-and-link.
    assign link_addr = seq_addr;
    assign link_we   = jal && !stall;
endmodule

// File: rtl/npc_checker.sv
// Property checker for npc_unit, attached by bind.
module npc_checker #(
    parameter int unsigned PC_W = 32,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0040_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic [1:0]      br_kind,
    input logic            ops_equal,
    input logic [15:0]     ofs16,
    input logic            jmp,
    input logic            jal,
    input logic            jreg,
    input logic [PC_W-1:0] jreg_val,
    input logic [PC_W-1:0] pc,
    input logic [PC_W-1:0] link_addr,
    input logic            link_we,
    input logic            misalign
);
    p_reset_pc_r1: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_PC);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !jreg && !jmp && !jal && (br_kind == 2'b00 || br_kind == 2'b11))
        |=> pc == $past(pc) + 32'd4);

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> pc == $past(pc));

    p_beq_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !jreg && !jmp && !jal && br_kind == 2'b01 && ops_equal)
        |=> pc == $past(pc) + 32'd4 + {{14{$past(ofs16[15])}}, $past(ofs16), 2'b00});

    p_jreg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (jreg && !stall) |=> pc == $past(jreg_val));

    p_link_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_addr == pc + 32'd4);

    p_link_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (jal && !stall));

    p_misalign_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (jreg && jreg_val[1:0] != 2'b00));
endmodule

bind npc_unit npc_checker #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .br_kind   (br_kind),
    .ops_equal (ops_equal),
    .ofs16     (ofs16),
    .jmp       (jmp),
    .jal       (jal),
    .jreg      (jreg),
    .jreg_val  (jreg_val),
    .pc        (pc),
    .link_addr (link_addr),
    .link_we   (link_we),
    .misalign  (misalign)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, stall, ops_equal, jmp, jal, jreg;
    logic [1:0]  br_kind;
    logic [15:0] ofs16;
    logic [25:0] tgt26;
    logic [31:0] jreg_val, pc, link_addr;
    logic        link_we, misalign;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .br_kind(br_kind),
        .ops_equal(ops_equal), .ofs16(ofs16), .tgt26(tgt26), .jmp(jmp),
        .jal(jal), .jreg(jreg), .jreg_val(jreg_val), .pc(pc),
        .link_addr(link_addr), .link_we(link_we), .misalign(misalign)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        stall = 0; br_kind = 2'b00; ops_equal = 0; ofs16 = '0; tgt26 = '0;
        jmp = 0; jal = 0; jreg = 0; jreg_val = '0;
    endtask

    // One edge, then settle away from it.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        idle_inputs(); rst_n = 0; stall = 1;
        step(); step();
        chk("R1 reset with stall", pc, 32'h0040_0000);
        rst_n = 1; stall = 0;
        exp_pc = 32'h0040_0000;
    endtask

    task automatic t_seq();
        for (int i = 0; i < 3; i++) begin
            step(); exp_pc += 4;
            chk("R2 sequential", pc, exp_pc);
        end
        br_kind = 2'b11; step(); exp_pc += 4;
        chk("R2 reserved code", pc, exp_pc);
        br_kind = 2'b00;
    endtask

    task automatic t_stall();
        stall = 1; br_kind = 2'b01; ops_equal = 1; ofs16 = 16'h0040;
        step(); step();
        chk("R3 stall hold", pc, exp_pc);
        chk("R8 link_we low", {31'd0, link_we}, 32'd0);
        idle_inputs();
    endtask

    task automatic t_beq();
        br_kind = 2'b01; ops_equal = 1; ofs16 = 16'h0010;
        step(); exp_pc = exp_pc + 4 + 32'h40;
        chk("R4 beq forward", pc, exp_pc);
        ofs16 = 16'hFFFC;
        step(); exp_pc = exp_pc + 4 - 16;
        chk("R4 beq backward", pc, exp_pc);
        ops_equal = 0;
        step(); exp_pc += 4;
        chk("R5 beq not taken", pc, exp_pc);
        idle_inputs();
    endtask

    task automatic t_bne();
        br_kind = 2'b10; ops_equal = 0; ofs16 = 16'h0003;
        step(); exp_pc = exp_pc + 4 + 12;
        chk("R5 bne taken", pc, exp_pc);
        ops_equal = 1;
        step(); exp_pc += 4;
        chk("R5 bne not taken", pc, exp_pc);
        idle_inputs();
    endtask

    task automatic t_jump();
        jmp = 1; tgt26 = 26'd2500;
        step(); exp_pc = 32'd10000;
        chk("R6 jump 2500", pc, exp_pc);
        idle_inputs(); jreg = 1; jreg_val = 32'hA000_0100;
        step(); exp_pc = 32'hA000_0100;
        idle_inputs(); jal = 1; tgt26 = 26'h10;
        #1 chk("R8 link_we on jal", {31'd0, link_we}, 32'd1);
        chk("R8 link addr", link_addr, 32'hA000_0104);
        step(); exp_pc = 32'hA000_0040;
        chk("R6 jal keeps upper bits", pc, exp_pc);
        idle_inputs();
    endtask

    task automatic t_priority();
        jreg = 1; jreg_val = 32'h0040_0200; jmp = 1; tgt26 = 26'h5;
        br_kind = 2'b01; ops_equal = 1; ofs16 = 16'h0007;
        step(); exp_pc = 32'h0040_0200;
        chk("R7 jreg over jump", pc, exp_pc);
        jreg = 0;
        step(); exp_pc = 32'h0000_0014;
        chk("R7 jump over branch", pc, exp_pc);
        idle_inputs();
    endtask

    task automatic t_misalign();
        jreg = 1; jreg_val = 32'h0040_0102;
        #1 chk("R9 misalign high", {31'd0, misalign}, 32'd1);
        step(); exp_pc = 32'h0040_0102;
        chk("R9 pc still loaded", pc, exp_pc);
        jreg_val = 32'h0040_0100;
        #1 chk("R9 aligned no flag", {31'd0, misalign}, 32'd0);
        idle_inputs();
        #1 chk("R9 flag off without jreg", {31'd0, misalign}, 32'd0);
        step(); exp_pc += 4;
        chk("R2 after unaligned", pc, exp_pc);
    endtask

    task automatic t_reset_mid();
        stall = 1; rst_n = 0;
        step();
        chk("R1 reset beats stall", pc, 32'h0040_0000);
        rst_n = 1; stall = 0;
    endtask

    initial begin
        rst_n = 0; idle_inputs();
        #3;
        t_reset();
        t_seq();
        t_stall();
        t_beq();
        t_bne();
        t_jump();
        t_priority();
        t_misalign();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule